// File: doc/BRIEF.md
# Replicated-State Passkey Lock

This block is a six-phase control sequencer with one gated phase. The gated phase exists as four interchangeable replicas. Each replica has the same predecessor and the same successor. When the sequencer arrives at the gate, the low bits of a per-chip identifier pick the replica it enters. Leaving that replica needs a passkey. The passkey is XORed with the identifier, and the result must equal the edge constant that belongs to the chosen replica.

The gate lies on the ordinary path of the sequence, so every trip around the cycle needs the key again. Authentication is therefore continuous and never a one-time unlock. A chip that receives a wrong key stalls at the gate and gives a one-cycle reject pulse for each attempt. A correct chip advances one phase per cycle while `advance` is high.

Top module: `replock_top`

## Requirements
- R1: After reset the phase output is 0, the reject pulse is low and the replica output is 0.
- R2: The phase output uses codes 0 to 5, and code 2 is the gate. Outside the gate, a cycle with `advance` high moves the phase on by one at the next clock edge, and the phase after 5 is 0. A cycle with `advance` low holds the phase.
- R3: On the edge that moves the phase from 1 to 2, the replica output takes the value `chipId[1:0]`. The replica output keeps that value until the next entry into the gate.
- R4: In the gate, a cycle with `keyValid` high and `passKey ^ chipId` equal to the selected replica's edge constant moves the phase to 3 at the next edge, whatever the value of `advance`.
- R5: In the gate, a cycle with `keyValid` high and a non-matching key keeps the phase at 2. It also raises `authFail` for exactly the following cycle, so an attempt on every cycle gives a pulse on every cycle.
- R6: In the gate, a cycle with `keyValid` low keeps the phase at 2 and raises no reject, even when `advance` is high.
- R7: The key is checked on every visit to the gate. A key that worked on an earlier pass gives no exemption on a later pass.
- R8: The four replicas have their own 16-bit edge constants: replica 0 uses 16'hA5C3, replica 1 uses 16'h3C96, replica 2 uses 16'h5AF0 and replica 3 uses 16'hC0DE. Replica i occupies bits [16*i +: 16] of the constant parameter. A key that is valid for a different replica is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipId | input | 16 | Per-chip identifier word |
| advance | input | 1 | Step request for the non-gated phases |
| keyValid | input | 1 | A passkey is presented in this cycle |
| passKey | input | 16 | Presented passkey |
| phase | output | 3 | Current phase code, 0 to 5 |
| replicaIdx | output | 2 | Replica chosen on the last entry into the gate |
| authFail | output | 1 | One-cycle pulse after a rejected key attempt |

## Verification
Two functions can meet in a single cycle: the reject pulse from a failed attempt, and a successful exit from the gate. The bench provokes this by presenting a wrong key and then the correct key on the very next cycle. It expects `authFail` to be high in the same cycle that the second attempt is evaluated, and expects the phase to reach 3 one edge later with the pulse already cleared. The scoreboard also judges the opposite overlap. A key is held valid while the sequencer enters the gate, and that key must not count until the sequencer is inside the gate.

// File: rtl/replock_pkg.sv
`timescale 1ns/1ps
package replock_pkg;
  localparam int REP_BITS = 2;
  localparam int NUM_REP  = 1 << REP_BITS;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PREP  = 3'd1,
    PH_GATE  = 3'd2,
    PH_RUN   = 3'd3,
    PH_DRAIN = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  typedef struct packed {
    logic                checkKey;
    logic [REP_BITS-1:0] lockSel;
  } strobe_t;
endpackage

// File: rtl/replock_datapath.sv
`timescale 1ns/1ps
module replock_datapath
  import replock_pkg::*;
#(
  parameter int IDW = 16,
  parameter logic [NUM_REP-1:0][IDW-1:0] EDGE_CONST = '0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [IDW-1:0] chipId,
  input  logic [IDW-1:0] passKey,
  input  strobe_t        strobe,
  output logic           keyMatch,
  output logic           authFail
);
  logic [IDW-1:0]     unmasked;
  logic [NUM_REP-1:0] hitVec;

  assign unmasked = passKey ^ chipId;

  for (genvar g = 0; g < NUM_REP; g++) begin : gEdge
    assign hitVec[g] = (unmasked == EDGE_CONST[g]);
  end

  assign keyMatch = hitVec[strobe.lockSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) authFail <= 1'b0;
    else       authFail <= strobe.checkKey & ~keyMatch;
  end

  // R5: a rejected attempt gives a pulse on the next cycle.
  assert_reject_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.checkKey && !keyMatch) |=> authFail);
  // R6: with no rejected attempt, no pulse follows.
  assert_no_spurious_fail_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.checkKey && !keyMatch) |=> !authFail);
endmodule

// File: rtl/replock_ctrl.sv
`timescale 1ns/1ps
module replock_ctrl
  import replock_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                advance,
  input  logic                keyValid,
  input  logic                keyMatch,
  input  logic [REP_BITS-1:0] chipSel,
  output phase_e              phaseQ,
  output logic [REP_BITS-1:0] repQ,
  output strobe_t             strobe
);
  phase_e phaseD;
  logic   enterGate;

  assign enterGate = (phaseQ == PH_PREP) && advance;

  always_comb begin
    phaseD = phaseQ;
    case (phaseQ)
      PH_GATE: if (keyValid && keyMatch) phaseD = PH_RUN;
      PH_IDLE:  if (advance) phaseD = PH_PREP;
      PH_PREP:  if (advance) phaseD = PH_GATE;
      PH_RUN:   if (advance) phaseD = PH_DRAIN;
      PH_DRAIN: if (advance) phaseD = PH_DONE;
      PH_DONE:  if (advance) phaseD = PH_IDLE;
      default:  phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      repQ   <= '0;
    end else begin
      phaseQ <= phaseD;
      if (enterGate) repQ <= chipSel;
    end
  end

  always_comb begin
    strobe.checkKey = (phaseQ == PH_GATE) && keyValid;
    strobe.lockSel  = repQ;
  end

  // R2: the phase code never leaves the range 0 to 5.
  assert_legal_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ <= PH_DONE);
  // R2: outside the gate, a step request changes the phase.
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != PH_GATE && advance) |=> phaseQ != $past(phaseQ));
  // R3: the replica is latched from the identifier on entry into the gate.
  assert_entry_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    enterGate |=> (phaseQ == PH_GATE && repQ == $past(chipSel)));
  // R3: the replica stays fixed while the sequencer is in the gate.
  assert_replica_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_GATE) |=> $stable(repQ));
  // R4: a matching key leaves the gate on the next edge.
  assert_gate_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_GATE && keyValid && keyMatch) |=> phaseQ == PH_RUN);
  // R5: a rejected key holds the gate.
  assert_reject_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_GATE && keyValid && !keyMatch) |=> phaseQ == PH_GATE);
  // R6: no key means no exit, whatever the step request.
  assert_nokey_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_GATE && !keyValid) |=> phaseQ == PH_GATE);
endmodule

// File: rtl/replock_top.sv
`timescale 1ns/1ps
module replock_top
  import replock_pkg::*;
#(
  parameter int IDW = 16,
  parameter logic [NUM_REP-1:0][IDW-1:0] EDGE_CONST =
    {16'hC0DE, 16'h5AF0, 16'h3C96, 16'hA5C3}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDW-1:0]      chipId,
  input  logic                advance,
  input  logic                keyValid,
  input  logic [IDW-1:0]      passKey,
  output logic [2:0]          phase,
  output logic [REP_BITS-1:0] replicaIdx,
  output logic                authFail
);
  strobe_t strobe;
  phase_e  phaseQ;
  logic    keyMatch;

  replock_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .advance  (advance),
    .keyValid (keyValid),
    .keyMatch (keyMatch),
    .chipSel  (chipId[REP_BITS-1:0]),
    .phaseQ   (phaseQ),
    .repQ     (replicaIdx),
    .strobe   (strobe)
  );

  replock_datapath #(.IDW(IDW), .EDGE_CONST(EDGE_CONST)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .chipId   (chipId),
    .passKey  (passKey),
    .strobe   (strobe),
    .keyMatch (keyMatch),
    .authFail (authFail)
  );

  assign phase = phaseQ;
endmodule

// File: tb/replock_top_test.sv
`timescale 1ns/1ps
module replock_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] chipId = '0;
  logic        advance = 1'b0;
  logic        keyValid = 1'b0;
  logic [15:0] passKey = '0;
  logic [2:0]  phase;
  logic [1:0]  replicaIdx;
  logic        authFail;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [2:0] ph;
    logic       fl;
    logic [1:0] rp;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  logic [3:0][15:0] edgeK = {16'hC0DE, 16'h5AF0, 16'h3C96, 16'hA5C3};
  logic [2:0] mPhase = 3'd0;
  logic [1:0] mRep = 2'd0;

  replock_top uut (
    .clk(clk), .rstN(rstN), .chipId(chipId), .advance(advance),
    .keyValid(keyValid), .passKey(passKey), .phase(phase),
    .replicaIdx(replicaIdx), .authFail(authFail)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] goodKey(input logic [15:0] c);
    return c ^ edgeK[c[1:0]];
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic stepCycle(input logic adv, input logic kv, input logic [15:0] key,
                           input logic [15:0] chip, input string tag);
    exp_t e;
    logic match, expFail;
    @(negedge clk);
    advance = adv; keyValid = kv; passKey = key; chipId = chip;
    match   = ((key ^ chip) == edgeK[mRep]);
    expFail = (mPhase == 3'd2) && kv && !match;
    if (mPhase == 3'd2) begin
      if (kv && match) mPhase = 3'd3;
    end else if (adv) begin
      if (mPhase == 3'd1) mRep = chip[1:0];
      mPhase = (mPhase == 3'd5) ? 3'd0 : mPhase + 3'd1;
    end
    e.ph = mPhase; e.fl = expFail; e.rp = mRep; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares each queued expectation after the edge it belongs to.
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, "phase", phase, e.ph);
      check(e.tag, "authFail", authFail, e.fl);
      check(e.tag, "replicaIdx", replicaIdx, e.rp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] chip;
    logic [15:0] bad;
    chip = 16'h1235;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1", "phase", phase, 0);
    check("R1", "authFail", authFail, 0);
    check("R1", "replicaIdx", replicaIdx, 0);
    @(negedge clk); rstN = 1'b1;

    // R2 and R3: step to the gate, with a key already presented before entry
    stepCycle(1, 1, goodKey(chip), chip, "R2");
    stepCycle(1, 1, goodKey(chip), chip, "R3");
    // R6: no key, with and without a step request
    repeat (2) stepCycle(0, 0, 16'h0, chip, "R6");
    repeat (2) stepCycle(1, 0, 16'h0, chip, "R6");
    // R4: exit even with advance low
    stepCycle(0, 1, goodKey(chip), chip, "R4");
    // R2: hold, then wrap around
    repeat (2) stepCycle(0, 0, 16'h0, chip, "R2");
    repeat (3) stepCycle(1, 0, 16'h0, chip, "R2");
    // R7: many full cycles with the right key
    for (int i = 0; i < 6; i++)
      repeat (6) stepCycle(1, 1, goodKey(chip), chip, "R7");
    // R5: swapped key mid-run, progress stops at the gate
    bad = goodKey(chip) ^ 16'h0100;
    repeat (10) stepCycle(1, 1, bad, chip, "R5");
    // R5 and R4: a rejected attempt immediately followed by the correct one
    stepCycle(1, 1, bad, chip, "R5");
    stepCycle(1, 1, goodKey(chip), chip, "R4");
    // R8: each replica uses its own edge constant
    for (int r = 0; r < 4; r++) begin
      logic [15:0] c;
      c = {14'h2A5 + 14'(r), 2'(r)};
      repeat (5) stepCycle(1, 0, 16'h0, c, "R8");
      stepCycle(1, 1, c ^ edgeK[(r + 1) % 4], c, "R8");
      stepCycle(1, 1, c ^ edgeK[(r + 2) % 4], c, "R8");
      stepCycle(1, 1, goodKey(c), c, "R8");
    end
    repeat (3) @(posedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule